// File: doc/BRIEF.md
# Reconfigurable Two-Level Compute Cluster

This block is a purely combinational compute cluster. It holds four processing nodes in two levels of two. Each node can run either an ALU function or a multiplication on two 16-bit operands. Only one of the two units drives the node result at a time.

The two first-level nodes always take their operands straight from the external inputs. Each operand of a second-level node passes through a steering multiplexer. That multiplexer picks either one of the first-level results or one of that node's own external operands.

A single configuration word therefore sets up any two-level template of chained two-operand operations. Examples are multiply-add, two sums feeding a product, or four independent operations side by side. No register sits between the levels. All four node results leave the block, so they can feed another cluster in the same cycle.

Top module: `cfc_cluster`

## Requirements
- R1: Operation code 000 gives a+b and 001 gives a-b, both wrapping modulo 2^16 (0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF).
- R2: Operation codes 010, 011 and 100 give bitwise AND, OR and XOR of the two operands.
- R3: Operation code 101 gives the low 16 bits of the product a*b (0xFFFF*0xFFFF gives 0x0001).
- R4: Operation code 110 passes operand A through unchanged, and 111 passes operand B.
- R5: First-level node k (k=0,1) always uses `opa_i[k]` and `opb_i[k]`, whatever the steering selects are set to.
- R6: Each operand of second-level node k (k=2,3) uses a 2-bit select: 00 takes first-level node 0's result, 01 takes first-level node 1's result, 10 takes `opa_i[k]`, and 11 takes `opb_i[k]`.
- R7: The block has no storage. Every output is a combinational function of the present inputs and settles in the same cycle the inputs change.
- R8: All four node results appear on `res_o[0..3]`, including first-level results that are also consumed by a second-level node.
- R9: The outputs of one cluster can drive the operand inputs of a second cluster, and the chained result is valid within the same cycle.
- R10: Configuration word layout: bits [3k+2:3k] hold the operation code of node k (k=0..3); bits [13:12] and [15:14] select operands A and B of node 2; bits [17:16] and [19:18] select operands A and B of node 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4x16 | External operand A for each node, indexed by node number |
| opb_i | input | 4x16 | External operand B for each node, indexed by node number |
| cfg_i | input | 20 | Configuration word: four operation codes and four steering selects |
| res_o | output | 4x16 | Result of each node, indexed by node number |

## Verification
The block holds no state, so any wrong internal choice shows on the ports within the very cycle the inputs are applied.

A wrong operation decode, a wrong truncation or a wrong steering select appears at once as a mismatch on the node output concerned. A fault on a first-level node also spreads to any second-level node that selects it. Random configuration words, applied every cycle, compare all four results against an independent model, so a single wrong field position shows up within a few vectors.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int unsigned OP_W     = 3;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned L1_NODES = 2;
    localparam int unsigned L2_NODES = 2;
    localparam int unsigned NODES    = L1_NODES + L2_NODES;
    localparam int unsigned SEL_BASE = NODES * OP_W;
    localparam int unsigned CFG_W    = SEL_BASE + L2_NODES * 2 * SEL_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_XOR   = 3'b100,
        OP_MUL   = 3'b101,
        OP_PASSA = 3'b110,
        OP_PASSB = 3'b111
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_L1N0 = 2'b00,
        SRC_L1N1 = 2'b01,
        SRC_EXTA = 2'b10,
        SRC_EXTB = 2'b11
    } src_e;

endpackage

// File: rtl/cfc_node.sv
module cfc_node
    import cfc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o
);

    localparam int unsigned PROD_W = 2 * W;

    typedef struct packed {
        logic [W-1:0] alu;
        logic [W-1:0] mul;
        logic [W-1:0] res;
    } node_t;

    node_t             node_d;
    logic [PROD_W-1:0] prod_d;
    op_e               op_d;

    always_comb begin
        op_d   = op_e'(op_i);
        prod_d = PROD_W'(a_i) * PROD_W'(b_i);
        node_d = '0;
        unique case (op_d)
            OP_ADD:   node_d.alu = a_i + b_i;
            OP_SUB:   node_d.alu = a_i - b_i;
            OP_AND:   node_d.alu = a_i & b_i;
            OP_OR:    node_d.alu = a_i | b_i;
            OP_XOR:   node_d.alu = a_i ^ b_i;
            OP_PASSA: node_d.alu = a_i;
            OP_PASSB: node_d.alu = b_i;
            default:  node_d.alu = '0;
        endcase
        // only one unit drives the node result
        node_d.mul = (op_d == OP_MUL) ? prod_d[W-1:0] : '0;
        node_d.res = (op_d == OP_MUL) ? node_d.mul : node_d.alu;
    end

    assign res_o = node_d.res;

    // Checks relating the node result to its operands
    always_comb begin
        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op_i == OP_ADD && b_i == '0)
                assert_add_zero_R1: assert (res_o == a_i)
                    else $error("add of zero altered operand");
            if (op_i == OP_XOR && a_i == b_i)
                assert_xor_self_R2: assert (res_o == '0)
                    else $error("xor of equal operands nonzero");
            if (op_i == OP_MUL && b_i == W'(1))
                assert_mul_unit_R3: assert (res_o == a_i)
                    else $error("multiply by one altered operand");
        end
    end

endmodule

// File: rtl/cfc_src_mux.sv
module cfc_src_mux
    import cfc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     l1n0_i,
    input  logic [W-1:0]     l1n1_i,
    input  logic [W-1:0]     ext_a_i,
    input  logic [W-1:0]     ext_b_i,
    output logic [W-1:0]     y_o
);

    logic [W-1:0] y_d;

    always_comb begin
        unique case (src_e'(sel_i))
            SRC_L1N0: y_d = l1n0_i;
            SRC_L1N1: y_d = l1n1_i;
            SRC_EXTA: y_d = ext_a_i;
            SRC_EXTB: y_d = ext_b_i;
            default:  y_d = '0;
        endcase
    end

    assign y_o = y_d;

endmodule

// File: rtl/cfc_cluster.sv
module cfc_cluster
    import cfc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [NODES-1:0][DATA_W-1:0] opa_i,
    input  logic [NODES-1:0][DATA_W-1:0] opb_i,
    input  logic [CFG_W-1:0]             cfg_i,
    output logic [NODES-1:0][DATA_W-1:0] res_o
);

    logic [NODES-1:0][DATA_W-1:0] node_res_d;
    logic [NODES-1:0][OP_W-1:0]   node_op_d;

    genvar gk;
    generate
        for (gk = 0; gk < NODES; gk++) begin : g_op
            assign node_op_d[gk] = cfg_i[gk*OP_W +: OP_W];
        end

        // first level: operands come only from the external inputs
        for (gk = 0; gk < L1_NODES; gk++) begin : g_l1
            cfc_node #(.W(DATA_W)) node_i (
                .a_i   (opa_i[gk]),
                .b_i   (opb_i[gk]),
                .op_i  (node_op_d[gk]),
                .res_o (node_res_d[gk])
            );
        end

        // second level: each operand steered independently
        for (gk = 0; gk < L2_NODES; gk++) begin : g_l2
            localparam int unsigned NIDX = L1_NODES + gk;
            localparam int unsigned SOFF = SEL_BASE + gk * 2 * SEL_W;
            logic [DATA_W-1:0] src_a_d;
            logic [DATA_W-1:0] src_b_d;

            cfc_src_mux #(.W(DATA_W)) mux_a_i (
                .sel_i   (cfg_i[SOFF +: SEL_W]),
                .l1n0_i  (node_res_d[0]),
                .l1n1_i  (node_res_d[1]),
                .ext_a_i (opa_i[NIDX]),
                .ext_b_i (opb_i[NIDX]),
                .y_o     (src_a_d)
            );
            cfc_src_mux #(.W(DATA_W)) mux_b_i (
                .sel_i   (cfg_i[SOFF+SEL_W +: SEL_W]),
                .l1n0_i  (node_res_d[0]),
                .l1n1_i  (node_res_d[1]),
                .ext_a_i (opa_i[NIDX]),
                .ext_b_i (opb_i[NIDX]),
                .y_o     (src_b_d)
            );
            cfc_node #(.W(DATA_W)) node_i (
                .a_i   (src_a_d),
                .b_i   (src_b_d),
                .op_i  (node_op_d[NIDX]),
                .res_o (node_res_d[NIDX])
            );
        end
    endgenerate

    assign res_o = node_res_d;

    // Cross-module checks on the steering between levels
    always_comb begin
        if (!$isunknown({opa_i, opb_i, cfg_i})) begin
            if (cfg_i[0 +: OP_W] == OP_PASSB)
                assert_l1_ext_R5: assert (res_o[0] == opb_i[0])
                    else $error("first-level node did not use external operand");
            if (cfg_i[2*OP_W +: OP_W] == OP_PASSA &&
                cfg_i[SEL_BASE +: SEL_W] == SRC_L1N1)
                assert_l2_fwd_R6: assert (res_o[2] == res_o[1])
                    else $error("second-level node missed first-level result");
            if (cfg_i[3*OP_W +: OP_W] == OP_PASSB &&
                cfg_i[SEL_BASE+3*SEL_W +: SEL_W] == SRC_EXTA)
                assert_l2_ext_R6: assert (res_o[3] == opa_i[3])
                    else $error("second-level node missed external operand");
        end
    end

endmodule

// File: tb/cfc_cluster_tb_top.sv
module cfc_cluster_tb_top;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [3:0][W-1:0] opa, opb, res;
    logic [19:0]       cfg;
    logic [3:0][W-1:0] ch_a, ch_b, ch_res;
    logic [19:0]       ch_cfg;

    int n_checks = 0;
    int n_fails  = 0;

    cfc_cluster dut_i (.opa_i(opa), .opb_i(opb), .cfg_i(cfg), .res_o(res));

    // second cluster fed directly by the first (R9)
    always_comb begin
        ch_a    = '0;
        ch_b    = '0;
        ch_a[0] = res[2];
        ch_b[0] = res[3];
    end
    cfc_cluster dut2_i (.opa_i(ch_a), .opb_i(ch_b), .cfg_i(ch_cfg), .res_o(ch_res));

    function automatic logic [W-1:0] model_op(int op, logic [W-1:0] a, logic [W-1:0] b);
        longint x;
        case (op)
            0: x = longint'(a) + longint'(b);
            1: x = longint'(a) - longint'(b);
            2: x = longint'(a & b);
            3: x = longint'(a | b);
            4: x = longint'(a ^ b);
            5: x = longint'(a) * longint'(b);
            6: x = longint'(a);
            default: x = longint'(b);
        endcase
        return W'(x & 64'hFFFF);
    endfunction

    function automatic string tag_of(int op);
        if (op <= 1) return "R1";
        if (op <= 4) return "R2";
        if (op == 5) return "R3";
        return "R4";
    endfunction

    function automatic logic [19:0] mk_cfg(int o0, int o1, int o2, int o3,
                                           int s2a, int s2b, int s3a, int s3b);
        logic [19:0] c;
        c = '0;
        c[2:0]   = 3'(o0);  c[5:3]   = 3'(o1);
        c[8:6]   = 3'(o2);  c[11:9]  = 3'(o3);
        c[13:12] = 2'(s2a); c[15:14] = 2'(s2b);
        c[17:16] = 2'(s3a); c[19:18] = 2'(s3b);
        return c;
    endfunction

    task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Full model comparison of all four outputs; fields per R10
    task automatic check_all(string ctx);
        logic [3:0][W-1:0] e;
        logic [W-1:0] sa, sb;
        int sel;
        for (int k = 0; k < 2; k++)
            e[k] = model_op(int'(cfg[3*k +: 3]), opa[k], opb[k]);
        for (int k = 2; k < 4; k++) begin
            sel = int'(cfg[12 + 4*(k-2) +: 2]);
            sa  = (sel == 0) ? e[0] : (sel == 1) ? e[1] : (sel == 2) ? opa[k] : opb[k];
            sel = int'(cfg[14 + 4*(k-2) +: 2]);
            sb  = (sel == 0) ? e[0] : (sel == 1) ? e[1] : (sel == 2) ? opa[k] : opb[k];
            e[k] = model_op(int'(cfg[3*k +: 3]), sa, sb);
        end
        for (int k = 0; k < 2; k++)
            chk({ctx, " R5 ", tag_of(int'(cfg[3*k +: 3]))}, res[k], e[k]);
        for (int k = 2; k < 4; k++)
            chk({ctx, " R6 ", tag_of(int'(cfg[3*k +: 3]))}, res[k], e[k]);
    endtask

    // drive just after a rising edge, sample at the following falling edge:
    // no storage, so outputs must already hold the result (R7)
    task automatic apply(logic [3:0][W-1:0] a, logic [3:0][W-1:0] b, logic [19:0] c);
        @(posedge clk);
        #1;
        opa = a; opb = b; cfg = c;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [3:0][W-1:0] a, b;
        opa = '0; opb = '0; cfg = '0; ch_cfg = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state: all-zero inputs give all-zero results (R7)
        for (int k = 0; k < 4; k++) chk("R7 idle", res[k], '0);

        // wrap boundaries R1, truncation R3
        a = '0; b = '0;
        a[0] = 16'hFFFF; b[0] = 16'h0001;
        a[1] = 16'h0000; b[1] = 16'h0001;
        a[2] = 16'hFFFF; b[2] = 16'hFFFF;
        a[3] = 16'h8000; b[3] = 16'h0002;
        apply(a, b, mk_cfg(0, 1, 5, 5, 2, 3, 2, 3));
        chk("R1 add wrap", res[0], 16'h0000);
        chk("R1 sub wrap", res[1], 16'hFFFF);
        chk("R3 mul trunc", res[2], 16'h0001);
        chk("R3 mul trunc", res[3], 16'h0000);

        // multiply-add: n0 = a0*b0, n2 = n0 + opb[2]
        a = '0; b = '0;
        a[0] = 16'd300; b[0] = 16'd7; b[2] = 16'd45;
        apply(a, b, mk_cfg(5, 7, 0, 6, 0, 3, 2, 3));
        chk("R6 mul-add", res[2], 16'd2145);
        chk("R8 l1 visible", res[0], 16'd2100);

        // two adds feeding a multiply: (5+6)*(7+8) = 165
        a = '0; b = '0;
        a[0] = 16'd5; b[0] = 16'd6; a[1] = 16'd7; b[1] = 16'd8;
        a[3] = 16'h1234; b[3] = 16'h00FF;
        apply(a, b, mk_cfg(0, 0, 5, 2, 0, 1, 2, 3));
        chk("R6 add-add-mul", res[2], 16'd165);
        chk("R8 l1 node1 visible", res[1], 16'd15);
        chk("R2 independent and", res[3], 16'h0034);
        check_all("directed");

        // R5: level-one ignores steering fields; vary selects only
        for (int s = 0; s < 4; s++) begin
            a = '0; b = '0;
            a[0] = 16'h00F0; b[0] = 16'h0F0F; a[1] = 16'hAAAA; b[1] = 16'h5555;
            apply(a, b, mk_cfg(3, 4, 6, 7, s, 3 - s, s, s));
            chk("R5 l1 OR", res[0], 16'h0FFF);
            chk("R5 l1 XOR", res[1], 16'hFFFF);
            check_all("select sweep");
        end

        // R9: second cluster adds the first cluster's level-two results
        a = '0; b = '0;
        a[2] = 16'd1000; b[3] = 16'd234;
        ch_cfg = mk_cfg(0, 0, 0, 0, 2, 3, 2, 3);
        apply(a, b, mk_cfg(0, 0, 6, 7, 2, 2, 3, 3));
        chk("R9 chained cluster", ch_res[0], 16'd1234);

        // random configurations against the model (R1..R6, R10)
        for (int v = 0; v < 400; v++) begin
            for (int k = 0; k < 4; k++) begin
                a[k] = W'($urandom);
                b[k] = W'($urandom);
            end
            apply(a, b, 20'($urandom));
            check_all("random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule